// File: doc/BRIEF.md
# Banked Data Address Decoder

This block sits between the data port of a small 8-bit controller core and its data memories. It takes each data address and resolves it into one of four destinations: a physical RAM bank and offset, the sixteen 8-bit core registers held inside the block, a peripheral select, or a fixed read value for regions that hold no storage.

The address space has two halves. The lower half (0x00–0x7F) is memory. It can be banked: when banking is enabled, the segment register (register 15) picks the bank. Accesses made by the stack always go to bank 0. In bank 0, the top sixteen bytes of the lower half hold no storage and read back as all-ones, so a stack underflow reads an invalid address. The upper half (0x80–0xFF) holds control registers and never depends on the segment register.

Read data for register, trap and undefined reads is combinational in the access cycle. Register writes take effect on the rising clock edge.

Top module: `dadec_top`

## Requirements
- R1: After reset, all sixteen registers at 0xF0–0xFF read 0x00.
- R2: A write to 0xF0–0xFF stores wdata into register addr[3:0] at the clock edge. A read of that address returns it with rd_valid=1 and rf_sel=1.
- R3: With banking disabled, an access to 0x00–0x6F asserts ram_sel with ram_bank=0 and ram_ofs=addr[6:0].
- R4: When the effective bank is 0, a read of 0x70–0x7F returns 0xFF with rd_valid=1 and ram_sel=0. A write there asserts no strobe.
- R5: With banking enabled and a non-stack access, a lower-half address goes to bank (register 15 mod NUM_BANKS). A non-zero bank serves all of 0x00–0x7F through ram_sel.
- R6: With stack_acc=1, the access targets bank 0 whatever register 15 holds.
- R7: With banking disabled, register 15 has no effect on decoding. It reads and writes like any other register.
- R8: Decoding of 0x80–0xFF does not depend on register 15 or on bank_en.
- R9: Accesses to 0x90–0xDF and 0xE9–0xEF assert per_sel and leave rd_valid at 0.
- R10: Reads of 0x80–0x8F and 0xE0–0xE8 return 0x00 with rd_valid=1. Writes there assert no strobe.
- R11: With neither rd_en nor wr_en, ram_sel, rf_sel, per_sel and rd_valid are all 0. rd_data is 0 whenever rd_valid is 0.
- R12: A write to 0xFF changes the bank used from the next access on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bank_en | input | 1 | Banking enable for the lower half |
| addr | input | 8 | CPU data address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| stack_acc | input | 1 | Access generated by the stack pointer |
| ram_sel | output | 1 | RAM access strobe |
| ram_bank | output | BANK_W | Physical RAM bank |
| ram_ofs | output | 7 | Offset within the bank |
| rf_sel | output | 1 | Register file selected |
| per_sel | output | 1 | Peripheral register selected |
| rd_valid | output | 1 | rd_data supplies the read value |
| rd_data | output | 8 | Read data for registers, trap and undefined regions |

## Verification
The assertions assume rd_en and wr_en are never high together. They also assume stack_acc is only raised with a lower-half address, as a stack pointer never points anywhere else. The stimulus picks one of idle, read or write for each cycle, and clears stack_acc whenever it chooses an upper-half address. Register 15 takes random values well above the bank count, which exercises the modulo wrap.

// File: rtl/dadec_pkg.sv
package dadec_pkg;
  typedef enum logic [2:0] {
    RG_LOW,     // 0x00-0x6F
    RG_LOWTOP,  // 0x70-0x7F
    RG_UNDEF,   // 0x80-0x8F, 0xE0-0xE8
    RG_PER,     // 0x90-0xDF, 0xE9-0xEF
    RG_RF       // 0xF0-0xFF
  } region_e;

  localparam logic [7:0] TRAP_VAL  = 8'hFF;
  localparam logic [7:0] UNDEF_VAL = 8'h00;
endpackage

// File: rtl/dadec_region.sv
module dadec_region
  import dadec_pkg::*;
(
  input  logic [7:0] addr,
  output region_e    region
);
  always_comb begin
    region = RG_PER;
    if (!addr[7]) begin
      region = (addr[6:4] == 3'b111) ? RG_LOWTOP : RG_LOW;
    end else begin
      unique case (addr[6:4])
        3'b000:  region = RG_UNDEF;
        3'b111:  region = RG_RF;
        3'b110:  region = (addr[3:0] <= 4'd8) ? RG_UNDEF : RG_PER;
        default: region = RG_PER;
      endcase
    end
  end
endmodule

// File: rtl/dadec_bankmap.sv
module dadec_bankmap #(
  parameter  int NUM_BANKS = 4,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [7:0]        seg,
  input  logic              bank_en,
  input  logic              stack_acc,
  output logic [BANK_W-1:0] bank,
  output logic              bank_is0
);
  logic [BANK_W-1:0] seg_bank;

  generate
    if (NUM_BANKS == 1) begin : g_single
      assign seg_bank = '0;
    end else begin : g_multi
      assign seg_bank = BANK_W'(seg % 8'(NUM_BANKS));
    end
  endgenerate

  always_comb begin
    bank = '0;
    if (bank_en && !stack_acc) bank = seg_bank;
    bank_is0 = (bank == '0);
  end
endmodule

// File: rtl/dadec_regfile.sv
module dadec_regfile #(
  parameter  int NREG = 16,
  localparam int IW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] ridx,
  output logic [7:0]    rdata,
  output logic [7:0]    seg
);
  logic [7:0] regs [NREG];

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic en;
      assign en = we && (widx == IW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  regs[g] <= 8'h00;
        else if (en) regs[g] <= wdata;
      end
    end
  endgenerate

  assign rdata = regs[ridx];
  assign seg   = regs[NREG-1];

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs[$past(widx)] == $past(wdata));
endmodule

// File: rtl/dadec_top.sv
module dadec_top
  import dadec_pkg::*;
#(
  parameter  int NUM_BANKS = 4,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_en,
  input  logic [7:0]        addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  input  logic              stack_acc,
  output logic              ram_sel,
  output logic [BANK_W-1:0] ram_bank,
  output logic [6:0]        ram_ofs,
  output logic              rf_sel,
  output logic              per_sel,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);
  logic [1:0] rst_sync;
  logic       rst_q;
  region_e    region;
  logic [7:0] seg, rf_rdata;
  logic       bank_is0, rf_we, any_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  dadec_region u_region (.addr(addr), .region(region));

  dadec_bankmap #(.NUM_BANKS(NUM_BANKS)) u_bankmap (
    .seg(seg), .bank_en(bank_en), .stack_acc(stack_acc),
    .bank(ram_bank), .bank_is0(bank_is0));

  assign any_acc = rd_en | wr_en;
  assign rf_we   = wr_en && (region == RG_RF);

  dadec_regfile #(.NREG(16)) u_regfile (
    .clk(clk), .rst_n(rst_q), .we(rf_we), .widx(addr[3:0]),
    .wdata(wdata), .ridx(addr[3:0]), .rdata(rf_rdata), .seg(seg));

  assign ram_ofs = addr[6:0];

  always_comb begin
    ram_sel  = 1'b0;
    rf_sel   = 1'b0;
    per_sel  = 1'b0;
    rd_valid = 1'b0;
    rd_data  = 8'h00;
    unique case (region)
      RG_LOW:    ram_sel = any_acc;
      RG_LOWTOP: begin
        if (bank_is0) begin
          rd_valid = rd_en;
          rd_data  = rd_en ? TRAP_VAL : 8'h00;
        end else begin
          ram_sel = any_acc;
        end
      end
      RG_UNDEF: begin
        rd_valid = rd_en;
        rd_data  = UNDEF_VAL;
      end
      RG_PER: per_sel = any_acc;
      RG_RF: begin
        rf_sel   = any_acc;
        rd_valid = rd_en;
        rd_data  = rd_en ? rf_rdata : 8'h00;
      end
      default: ;
    endcase
  end

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({ram_sel, rf_sel, per_sel}));
  p_upper_no_ram_r8: assert property (@(posedge clk) disable iff (!rst_q)
    addr[7] |-> !ram_sel);
  p_stack_bank0_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (stack_acc && ram_sel) |-> (ram_bank == '0));
  p_trap_val_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_valid && !addr[7]) |-> (rd_data == 8'hFF && ram_bank == '0));
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_q)
    !any_acc |-> !(ram_sel || rf_sel || per_sel || rd_valid));
  p_bank_range_r5: assert property (@(posedge clk) disable iff (!rst_q)
    ram_sel |-> (int'(ram_bank) < NUM_BANKS));
  p_seg_next_r12: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(rst_q) && $past(wr_en && addr == 8'hFF) && bank_en && !stack_acc && ram_sel)
      |-> (int'(ram_bank) == int'($past(wdata)) % NUM_BANKS));
endmodule

// File: tb/dadec_top_tb.sv
module dadec_top_tb;
  localparam int NB = 4;
  localparam int BW = $clog2(NB);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bank_en = 1'b0, rd_en = 1'b0, wr_en = 1'b0, stack_acc = 1'b0;
  logic [7:0]    addr = 8'h00, wdata = 8'h00;
  logic          ram_sel, rf_sel, per_sel, rd_valid;
  logic [BW-1:0] ram_bank;
  logic [6:0]    ram_ofs;
  logic [7:0]    rd_data;

  logic [7:0] model [16];
  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dadec_top #(.NUM_BANKS(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .bank_en(bank_en), .addr(addr), .rd_en(rd_en),
    .wr_en(wr_en), .wdata(wdata), .stack_acc(stack_acc), .ram_sel(ram_sel),
    .ram_bank(ram_bank), .ram_ofs(ram_ofs), .rf_sel(rf_sel), .per_sel(per_sel),
    .rd_valid(rd_valid), .rd_data(rd_data));

  function automatic string tag_of(logic [7:0] a, bit ben, bit stk, bit rd, bit wr);
    if (!(rd || wr))                          return "R11";
    if (a >= 8'hF0)                           return (a == 8'hFF) ? "R7/R2" : "R2";
    if (a < 8'h80 && stk)                     return "R6";
    if (a < 8'h80 && ben)                     return "R5/R12";
    if (a >= 8'h70 && a < 8'h80)              return "R4";
    if (a < 8'h70)                            return "R3";
    if (a < 8'h90 || (a >= 8'hE0 && a <= 8'hE8)) return "R10";
    return "R9/R8";
  endfunction

  task automatic apply(input bit rd, input bit wr, input logic [7:0] a,
                       input logic [7:0] wd, input bit ben, input bit stk);
    bit e_ram, e_rf, e_per, e_val, ok;
    logic [7:0] e_data;
    int eb, any;
    @(negedge clk);
    rd_en = rd; wr_en = wr; addr = a; wdata = wd; bank_en = ben; stack_acc = stk;
    #2;
    any = rd || wr;
    eb  = (ben && !stk) ? (int'(model[15]) % NB) : 0;
    e_ram = 0; e_rf = 0; e_per = 0; e_val = 0; e_data = 8'h00;
    if (a < 8'h80) begin
      if (eb == 0 && a >= 8'h70) begin e_val = rd; e_data = rd ? 8'hFF : 8'h00; end
      else e_ram = any;
    end else if (a < 8'h90 || (a >= 8'hE0 && a <= 8'hE8)) begin
      e_val = rd;
    end else if (a >= 8'hF0) begin
      e_rf = any; e_val = rd; e_data = rd ? model[a[3:0]] : 8'h00;
    end else begin
      e_per = any;
    end
    ok = (ram_sel === e_ram) && (rf_sel === e_rf) && (per_sel === e_per) &&
         (rd_valid === e_val) && (rd_data === e_data);
    if (e_ram) ok = ok && (int'(ram_bank) == eb) && (ram_ofs === a[6:0]);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s addr=%h: got ram=%b bank=%0d ofs=%h rf=%b per=%b val=%b data=%h, expected ram=%b bank=%0d ofs=%h rf=%b per=%b val=%b data=%h",
        tag_of(a, ben, stk, rd, wr), a, ram_sel, ram_bank, ram_ofs, rf_sel, per_sel,
        rd_valid, rd_data, e_ram, eb, a[6:0], e_rf, e_per, e_val, e_data);
    end
    if (wr && a >= 8'hF0) model[a[3:0]] = wd;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset values of all registers
    for (int i = 0; i < 16; i++) apply(1, 0, 8'hF0 + 8'(i), 8'h00, 0, 0);
    // R11: idle
    apply(0, 0, 8'h10, 8'h00, 1, 0);
    // R3 and R4 with banking off
    apply(1, 0, 8'h6F, 8'h00, 0, 0);
    apply(1, 0, 8'h70, 8'h00, 0, 0);
    apply(0, 1, 8'h7F, 8'h33, 0, 0);
    // R7: S has no effect when banking off; R15 is a plain register
    apply(0, 1, 8'hFF, 8'h07, 0, 0);
    apply(1, 0, 8'h75, 8'h00, 0, 0);
    apply(1, 0, 8'hFF, 8'h00, 0, 0);
    // R12: S=0x05 applies on the next access -> bank 1, full 128 bytes (R5)
    apply(0, 1, 8'hFF, 8'h05, 1, 0);
    apply(1, 0, 8'h7F, 8'h00, 1, 0);
    // R5: wrap, S=0x08 -> bank 0, trap again
    apply(0, 1, 8'hFF, 8'h08, 1, 0);
    apply(1, 0, 8'h72, 8'h00, 1, 0);
    // R6: stack access ignores S
    apply(0, 1, 8'hFF, 8'h03, 1, 0);
    apply(1, 0, 8'h7E, 8'h00, 1, 1);
    apply(0, 1, 8'h20, 8'h11, 1, 1);
    // R8/R9/R10: upper half boundaries with S non-zero
    apply(1, 0, 8'h8F, 8'h00, 1, 0);
    apply(1, 0, 8'h90, 8'h00, 1, 0);
    apply(1, 0, 8'hE8, 8'h00, 1, 0);
    apply(0, 1, 8'hE9, 8'h44, 1, 0);
    apply(0, 1, 8'h80, 8'h55, 1, 0);
    apply(1, 0, 8'hEF, 8'h00, 0, 0);

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int op;
      logic [7:0] a;
      bit stk;
      op  = int'($urandom % 3);
      a   = 8'($urandom);
      if ($urandom % 6 == 0) a = 8'hF0 | 8'($urandom % 16);
      stk = (a < 8'h80) ? bit'($urandom % 4 == 0) : 1'b0;
      apply(op == 1, op == 2, a, 8'($urandom), bit'($urandom % 2), stk);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule